// File: doc/BRIEF.md
# Scan Interconnect Short/Open Analyser

This block runs the sequencing side of a board interconnect test. One conventional net can be forced from outside the scan chain, and a set of boundary-scan input cells watch their own pins. Once started, the analyser asks for the forced net to be driven high and requests a scan capture of the input cells. It then asks for the net to be driven low and requests a second capture. This high/low pair is one round, and the whole sequence repeats for a programmable number of rounds.

Every capture is folded into per-node evidence as soon as it arrives. A node that reads high after every high drive and low after every low drive tracks the forced net on every transition, so it is reported as shorted to it. A node that reads the same value in both captures of every round never reacts, so it is reported as open. Any other node, such as one that follows some transitions but not all, is reported as inconclusive. The serial shifting of the scan chain and the physical forcing of the net are done outside this block. The block only exchanges requests and capture words with them.

Top module: `scan_link_analyser`

## Requirements
- R1: After reset, `done_o`, `res_valid_o`, `drv_req_o`, `scan_req_o` and all three flag vectors are 0.
- R2: `rounds_i` is sampled in the cycle a start is accepted. A value from 1 to 15 gives that many rounds, and 0 gives the default of 4 rounds. One run issues exactly 2×rounds drive requests, and `drv_val_o` alternates 1, 0, 1, 0, … starting with 1.
- R3: Each `drv_req_o` is a single-cycle pulse. `scan_req_o` is high in the next cycle and stays high until a cycle in which `scan_vld_i` is also high. `scan_word_i` is taken in that cycle only. `scan_vld_i` has no effect while `scan_req_o` is low, and the two requests are never high together.
- R4: Bit i of `short_o` is 1 when node i read 1 in every capture after a high drive and 0 in every capture after a low drive.
- R5: Bit i of `open_o` is 1 when, in every round, the two captures of node i are equal.
- R6: Bit i of `incon_o` is 1 when neither R4 nor R5 holds for node i. While `res_valid_o` is 1, exactly one of the three flags is set for each node.
- R7: `done_o` is high for exactly one cycle: the cycle after the final capture handshake. The flags take their verdicts at the same edge, and `res_valid_o` rises with `done_o`.
- R8: Accepting a start clears `res_valid_o` and all flags in the next cycle, and `drv_req_o` is high in that cycle. `start_i` is ignored while a run is in progress. A start given in the same cycle as `done_o` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run (accepted when idle) |
| rounds_i | input | ROUND_W | Round count; 0 selects DEF_ROUNDS |
| drv_req_o | output | 1 | One-cycle request to force the test net |
| drv_val_o | output | 1 | Value to force, valid with drv_req_o |
| scan_req_o | output | 1 | Capture request, held until accepted |
| scan_vld_i | input | 1 | Capture word present |
| scan_word_i | input | NODES | Captured boundary-scan input values |
| short_o | output | NODES | Node tracked every transition |
| open_o | output | NODES | Node never reacted |
| incon_o | output | NODES | Node neither shorted nor open |
| res_valid_o | output | 1 | Flags hold a finished verdict |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The end of one run and the start of the next can fall in the same cycle, because the sequencer is already idle while `done_o` is high. The bench raises `start_i` in exactly the cycle it sees `done_o`. It then expects a drive request with value 1 in the next cycle, and it expects the verdicts and `res_valid_o` to be cleared in that cycle. A second case is a capture-valid that arrives in the very cycle the capture request rises. The bench provokes it with zero-delay responses mixed among random delays, together with stray valids and starts given during a run. Every run's verdicts are compared with flags that the bench computes from the words it supplied.

// File: rtl/scan_link_pkg.sv
package scan_link_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRIVE = 2'd1,
      ST_SCAN  = 2'd2
   } seq_state_t;

endpackage

// File: rtl/sla_sequencer.sv
module sla_sequencer
   import scan_link_pkg::*;
#(
   parameter int ROUND_W    = 4,
   parameter int DEF_ROUNDS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [ROUND_W-1:0] rounds_i,
   output logic               drv_req_o,
   output logic               drv_val_o,
   output logic               scan_req_o,
   input  logic               scan_vld_i,
   output logic               clr_o,
   output logic               cap_stb_o,
   output logic               cap_hi_o,
   output logic               cap_last_o
);

   localparam logic [ROUND_W-1:0] DEF_CNT = ROUND_W'(DEF_ROUNDS);
   localparam logic [ROUND_W-1:0] ONE_CNT = ROUND_W'(1);

   seq_state_t         state_q, state_d;
   logic               hi_phase_q, hi_phase_d;
   logic [ROUND_W-1:0] left_q, left_d;
   logic               accept;
   logic               taken;

   assign accept     = (state_q == ST_IDLE) && start_i;
   assign taken      = (state_q == ST_SCAN) && scan_vld_i;
   assign clr_o      = accept;
   assign cap_stb_o  = taken;
   assign cap_hi_o   = hi_phase_q;
   assign cap_last_o = taken && !hi_phase_q && (left_q == ONE_CNT);

   assign drv_req_o  = (state_q == ST_DRIVE);
   assign drv_val_o  = (state_q == ST_DRIVE) && hi_phase_q;
   assign scan_req_o = (state_q == ST_SCAN);

   always_comb begin
      state_d    = state_q;
      hi_phase_d = hi_phase_q;
      left_d     = left_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d    = ST_DRIVE;
               hi_phase_d = 1'b1;
               left_d     = (rounds_i == '0) ? DEF_CNT : rounds_i;
            end
         end
         ST_DRIVE: state_d = ST_SCAN;
         ST_SCAN: begin
            if (scan_vld_i) begin
               if (hi_phase_q) begin
                  hi_phase_d = 1'b0;
                  state_d    = ST_DRIVE;
               end else if (left_q == ONE_CNT) begin
                  state_d = ST_IDLE;
               end else begin
                  left_d     = left_q - ONE_CNT;
                  hi_phase_d = 1'b1;
                  state_d    = ST_DRIVE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         hi_phase_q <= 1'b0;
         left_q     <= '0;
      end else begin
         state_q    <= state_d;
         hi_phase_q <= hi_phase_d;
         left_q     <= left_d;
      end
   end

   // R3
   scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_req_o && !scan_vld_i) |=> scan_req_o);

   // R3
   drv_then_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_req_o |=> (scan_req_o && !drv_req_o));

   // R3
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_req_o && scan_req_o));

   // R2
   first_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_o |=> (drv_req_o && drv_val_o));

   // R2
   pair_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_stb_o && cap_hi_o) |=> (drv_req_o && !drv_val_o));

endmodule

// File: rtl/sla_node_cell.sv
module sla_node_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic stb_i,
   input  logic hi_i,
   input  logic bit_i,
   output logic fin_follow_o,
   output logic fin_same_o
);

   logic hi_q;
   logic follow_q;
   logic same_q;

   // evidence including the low capture now being presented
   assign fin_follow_o = follow_q & hi_q & ~bit_i;
   assign fin_same_o   = same_q & (hi_q ~^ bit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= 1'b0;
         follow_q <= 1'b0;
         same_q   <= 1'b0;
      end else if (clr_i) begin
         follow_q <= 1'b1;
         same_q   <= 1'b1;
      end else if (stb_i) begin
         if (hi_i) begin
            hi_q <= bit_i;
         end else begin
            follow_q <= fin_follow_o;
            same_q   <= fin_same_o;
         end
      end
   end

   // R4
   follow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!follow_q && !clr_i) |=> !follow_q);

   // R5
   same_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!same_q && !clr_i) |=> !same_q);

endmodule

// File: rtl/sla_verdict.sv
module sla_verdict #(
   parameter int NODES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             fin_i,
   input  logic [NODES-1:0] follow_i,
   input  logic [NODES-1:0] same_i,
   output logic [NODES-1:0] short_o,
   output logic [NODES-1:0] open_o,
   output logic [NODES-1:0] incon_o,
   output logic             res_valid_o,
   output logic             done_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         short_o     <= '0;
         open_o      <= '0;
         incon_o     <= '0;
         res_valid_o <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         done_o <= fin_i;
         if (clr_i) begin
            short_o     <= '0;
            open_o      <= '0;
            incon_o     <= '0;
            res_valid_o <= 1'b0;
         end else if (fin_i) begin
            short_o     <= follow_i;
            open_o      <= same_i;
            incon_o     <= ~(follow_i | same_i);
            res_valid_o <= 1'b1;
         end
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   done_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_i |=> (done_o && res_valid_o));

   // R8
   clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!res_valid_o && short_o == '0 && open_o == '0 && incon_o == '0));

   for (genvar g = 0; g < NODES; g++) begin : g_node_chk
      // R6
      one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid_o |-> ($countones({short_o[g], open_o[g], incon_o[g]}) == 1));
   end

endmodule

// File: rtl/scan_link_analyser.sv
module scan_link_analyser
   import scan_link_pkg::*;
#(
   parameter int NODES      = 16,
   parameter int ROUND_W    = 4,
   parameter int DEF_ROUNDS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [ROUND_W-1:0] rounds_i,
   output logic               drv_req_o,
   output logic               drv_val_o,
   output logic               scan_req_o,
   input  logic               scan_vld_i,
   input  logic [NODES-1:0]   scan_word_i,
   output logic [NODES-1:0]   short_o,
   output logic [NODES-1:0]   open_o,
   output logic [NODES-1:0]   incon_o,
   output logic               res_valid_o,
   output logic               done_o
);

   localparam int MAX_ROUNDS = (1 << ROUND_W) - 1;

   if (NODES < 1) begin : g_bad_nodes
      $error("scan_link_analyser: NODES must be at least 1");
   end
   if (ROUND_W < 1 || ROUND_W > 8) begin : g_bad_rw
      $error("scan_link_analyser: ROUND_W must be 1..8");
   end
   if (DEF_ROUNDS < 1 || DEF_ROUNDS > MAX_ROUNDS) begin : g_bad_def
      $error("scan_link_analyser: DEF_ROUNDS out of range");
   end

   logic             clr;
   logic             cap_stb;
   logic             cap_hi;
   logic             cap_last;
   logic [NODES-1:0] fin_follow;
   logic [NODES-1:0] fin_same;

   sla_sequencer #(
      .ROUND_W    (ROUND_W),
      .DEF_ROUNDS (DEF_ROUNDS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .rounds_i   (rounds_i),
      .drv_req_o  (drv_req_o),
      .drv_val_o  (drv_val_o),
      .scan_req_o (scan_req_o),
      .scan_vld_i (scan_vld_i),
      .clr_o      (clr),
      .cap_stb_o  (cap_stb),
      .cap_hi_o   (cap_hi),
      .cap_last_o (cap_last)
   );

   for (genvar n = 0; n < NODES; n++) begin : g_cell
      sla_node_cell u_cell (
         .clk          (clk),
         .rst_n        (rst_n),
         .clr_i        (clr),
         .stb_i        (cap_stb),
         .hi_i         (cap_hi),
         .bit_i        (scan_word_i[n]),
         .fin_follow_o (fin_follow[n]),
         .fin_same_o   (fin_same[n])
      );
   end

   sla_verdict #(
      .NODES (NODES)
   ) u_verdict (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr),
      .fin_i       (cap_last),
      .follow_i    (fin_follow),
      .same_i      (fin_same),
      .short_o     (short_o),
      .open_o      (open_o),
      .incon_o     (incon_o),
      .res_valid_o (res_valid_o),
      .done_o      (done_o)
   );

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_req_o && !scan_vld_i) |=> !drv_req_o);

endmodule

// File: tb/tb_scan_link_analyser.sv
module tb_scan_link_analyser;

   localparam int NODES    = 16;
   localparam int ROUND_W  = 4;
   localparam int CLK_PER  = 10;
   localparam int WD_LIMIT = 150000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic [ROUND_W-1:0] rounds_i = '0;
   logic               drv_req_o, drv_val_o, scan_req_o;
   logic               scan_vld_i = 1'b0;
   logic [NODES-1:0]   scan_word_i = '0;
   logic [NODES-1:0]   short_o, open_o, incon_o;
   logic               res_valid_o, done_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   logic [NODES-1:0] caps [0:29];

   scan_link_analyser #(.NODES(NODES), .ROUND_W(ROUND_W), .DEF_ROUNDS(4)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rounds_i(rounds_i),
      .drv_req_o(drv_req_o), .drv_val_o(drv_val_o), .scan_req_o(scan_req_o),
      .scan_vld_i(scan_vld_i), .scan_word_i(scan_word_i),
      .short_o(short_o), .open_o(open_o), .incon_o(incon_o),
      .res_valid_o(res_valid_o), .done_o(done_o)
   );

   always #(CLK_PER/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected verdicts from the supplied captures
   function automatic void expect_flags(input int r, output logic [NODES-1:0] sh,
                                        output logic [NODES-1:0] op);
      sh = '1;
      op = '1;
      for (int k = 0; k < r; k++) begin
         sh = sh & caps[2*k] & ~caps[2*k+1];
         op = op & ~(caps[2*k] ^ caps[2*k+1]);
      end
   endfunction

   // per node behaviour: 0 short, 1 open, 2 partial follower, 3 random, 4 inverted
   task automatic build_caps(input int r, input int forced_kind);
      for (int s = 0; s < 2*r; s++) caps[s] = '0;
      for (int n = 0; n < NODES; n++) begin
         int kind;
         int brk;
         bit v;
         kind = (forced_kind >= 0) ? forced_kind : int'($urandom % 5);
         brk  = int'($urandom % r);
         v    = 1'($urandom);
         for (int k = 0; k < r; k++) begin
            case (kind)
               0: begin caps[2*k][n] = 1'b1; caps[2*k+1][n] = 1'b0; end
               1: begin caps[2*k][n] = v;    caps[2*k+1][n] = v;    end
               2: begin
                  caps[2*k][n]   = 1'b1;
                  caps[2*k+1][n] = (k == brk);
               end
               3: begin caps[2*k][n] = 1'($urandom); caps[2*k+1][n] = 1'($urandom); end
               default: begin caps[2*k][n] = 1'b0; caps[2*k+1][n] = 1'b1; end
            endcase
         end
      end
   endtask

   // started: start already accepted at the previous edge; chain_r >= 0 starts next run at done
   task automatic run_test(input int rin, input bit started, input int chain_r,
                           input bit noise, input int forced_kind);
      int r, step, hs, dly;
      bit fin, first;
      logic [NODES-1:0] e_sh, e_op;
      r = (rin == 0) ? 4 : rin;
      build_caps(r, forced_kind);
      expect_flags(r, e_sh, e_op);
      if (!started) begin
         @(negedge clk); cyc++;
         start_i = 1'b1;
         rounds_i = ROUND_W'(rin);
      end
      step = 0; hs = -10; dly = -1; fin = 0; first = 1;
      while (!fin) begin
         @(negedge clk); cyc++;
         start_i = 1'b0;
         if (cyc > WD_LIMIT) begin
            check(0, "WD", "watchdog expired", cyc, WD_LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
         if (first) begin
            // R8: start clears verdicts and begins with a drive
            check(!res_valid_o && short_o == '0 && open_o == '0 && incon_o == '0,
                  "R8", "clear on start", {res_valid_o, short_o}, 0);
            check(drv_req_o === 1'b1, "R8", "drive after start", drv_req_o, 1);
            first = 0;
         end
         if (done_o) begin
            check(cyc == hs + 1, "R7", "done timing", cyc, hs + 1);
            check(step == 2*r, "R2", "drive count", step, 2*r);
            check(short_o == e_sh, "R4", "short flags", short_o, e_sh);
            check(open_o == e_op, "R5", "open flags", open_o, e_op);
            check(incon_o == ~(e_sh | e_op), "R6", "inconclusive flags", incon_o, ~(e_sh | e_op));
            check(res_valid_o, "R7", "valid with done", res_valid_o, 1);
            scan_vld_i = 1'b0;
            if (chain_r >= 0) begin
               start_i = 1'b1;
               rounds_i = ROUND_W'(chain_r);
            end
            fin = 1;
         end else begin
            if (drv_req_o) begin
               check(drv_val_o == !step[0], "R2", "drive value", drv_val_o, !step[0]);
               check(!scan_req_o, "R3", "requests exclusive", scan_req_o, 0);
               step++;
               dly = -1;
            end
            if (scan_req_o) begin
               if (dly < 0) dly = int'($urandom % 4);
               if (dly == 0) begin
                  scan_vld_i  = 1'b1;
                  scan_word_i = caps[step-1];
                  hs = cyc;
                  dly = -1;
               end else begin
                  scan_vld_i  = 1'b0;
                  scan_word_i = $urandom;
                  dly--;
               end
            end else begin
               // R3: stray valid while no capture is requested
               scan_vld_i  = noise && ($urandom % 3 == 0);
               scan_word_i = $urandom;
            end
            // R8: starts during a run are ignored
            if (noise && ($urandom % 6 == 0)) begin
               start_i  = 1'b1;
               rounds_i = $urandom;
            end
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5ca7_2024));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!done_o && !res_valid_o, "R1", "done/valid in reset", {done_o, res_valid_o}, 0);
      check(!drv_req_o && !scan_req_o, "R1", "requests in reset", {drv_req_o, scan_req_o}, 0);
      check(short_o == '0 && open_o == '0 && incon_o == '0, "R1", "flags in reset", short_o, 0);
      rst_n = 1'b1;
      @(negedge clk); cyc++;
      check(!done_o && !drv_req_o && !scan_req_o, "R1", "idle after reset",
            {done_o, drv_req_o, scan_req_o}, 0);

      run_test(1, 0, -1, 0, 0);     // R4: one round, all shorted
      run_test(0, 0, -1, 0, 2);     // R2: default rounds, partial followers
      run_test(15, 0, -1, 1, -1);   // R2: maximum rounds
      run_test(3, 0, 5, 1, -1);     // R8: chained start in done cycle
      run_test(5, 1, -1, 1, 1);     // R5: all open, started from done cycle
      run_test(2, 0, -1, 0, 4);     // R6: inverted nodes
      for (int t = 0; t < 12; t++) begin
         run_test(int'($urandom % 16), 0, -1, 1, -1);
      end

      @(negedge clk); cyc++;
      check(!done_o, "R7", "done single cycle", done_o, 0);
      check(res_valid_o, "R7", "valid holds", res_valid_o, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule